// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master side of a 1-Wire bus. It drives one shared open-drain line through a small set of byte-wide registers. Software picks the operation by setting one command bit in the control register: a bus reset with presence detection, a write-0 slot, or a write-1/read slot. It then polls that register until the bit drops back to zero. At that point the control register also holds what was sampled from the line: a presence flag after a reset, and the line level after a bit slot.

All slot timing counts microsecond ticks. A prescaler makes these ticks from the system clock. Software loads it with the clock frequency in MHz minus one. The block never drives the line high. It only raises a pull-low enable for an external open-drain pad. The returning line level passes through a synchronizer chain before the state machine samples it. The register window also contains reset, command, transfer, interrupt and interrupt-enable registers. Writes to them are accepted, they read as zero, and they do nothing.

Top module: `owire_master`

## Requirements
- R1: Register offsets: control at 0x0 and divider at 0x2, both readable. Writes to 0x4, 0x6, 0x8, 0xA and 0xC are accepted, read back as 0x00, and change neither the control register nor the line.
- R2: One microsecond tick lasts (divider + 1) clock cycles. Every phase duration below is a whole number of ticks, counted from the clock edge that accepts the command.
- R3: Writing control bit 7 starts a reset sequence. Bit 7 reads 1 for 960 ticks and then clears by itself. The line is pulled low for the first 480 ticks.
- R4: Control bit 6 (presence) captures 1 if the synchronized line is low at tick 550 of a reset sequence, and 0 otherwise. Only a reset sequence changes it.
- R5: Writing control bit 5 starts a write-0 slot. Bit 5 reads 1 for 70 ticks. The line is pulled low for the first 60 ticks.
- R6: Writing control bit 4 starts a write-1/read slot. Bit 4 reads 1 for 70 ticks. The line is pulled low for the first 6 ticks.
- R7: Control bit 3 holds the synchronized line level at tick 15 of the most recent bit slot, so a write-0 slot always leaves 0 there. A reset sequence leaves bit 3 unchanged.
- R8: A control write arriving while an operation is active is ignored. This includes a write on the very clock edge at which the operation finishes.
- R9: When several command bits are written together, only one operation starts. Reset takes precedence, then write-0, then write-1/read. A control write with none of bits 7, 5 or 4 set starts nothing. Bits 2..0 always read 0.
- R10: After reset the control register reads 0x00, the divider reads 99, and the pull-low output is 0. The pull-low output is never 1 while no operation is active.
- R11: A divider write while an operation is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| line_in | input | 1 | Level seen on the bus line |
| line_pull_low | output | 1 | Enable for the open-drain pull-down of the pad |

## Verification
Two things can land on the same clock edge: the final tick of an operation, which clears its busy bit, and a new control write. The bench provokes this by placing a command write exactly on that edge, for both directed and random operations. It then judges that the write was dropped: all command bits read zero on the next cycle and the line stays released. A second pairing is a divider or command write sent in the first cycles of an operation. It is judged by checking that the busy pattern, the phase lengths and the divider readback are unchanged.

// File: rtl/owire_pkg.sv
package owire_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_RESET = 2'd1,
      OP_WR0   = 2'd2,
      OP_WR1   = 2'd3
   } op_e;

   // Control register bit positions (software decodes these)
   localparam int CB_RST  = 7;
   localparam int CB_PRES = 6;
   localparam int CB_WR0  = 5;
   localparam int CB_WR1  = 4;
   localparam int CB_BIT  = 3;

   // Priority pick among command bits: reset, then write-0, then write-1
   function automatic op_e pick_op(input logic [7:0] d);
      if (d[CB_RST])      return OP_RESET;
      else if (d[CB_WR0]) return OP_WR0;
      else if (d[CB_WR1]) return OP_WR1;
      else                return OP_IDLE;
   endfunction
endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pre_q;

   assign tick = (pre_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (restart || tick) pre_q <= '0;
      else                     pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
   import owire_pkg::*;
#(
   parameter int T_RST_LOW  = 480,
   parameter int T_RST_SMP  = 550,
   parameter int T_RST_END  = 960,
   parameter int T_W0_LOW   = 60,
   parameter int T_W0_END   = 70,
   parameter int T_W1_LOW   = 6,
   parameter int T_BIT_SMP  = 15,
   parameter int T_W1_END   = 70,
   parameter int US_W       = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   input  op_e  start_op,
   input  logic line_s,
   output op_e  cur_op,
   output logic pull_low,
   output logic bit_q,
   output logic pres_q
);
   localparam logic [US_W-1:0] RL  = US_W'(T_RST_LOW);
   localparam logic [US_W-1:0] RS  = US_W'(T_RST_SMP - 1);
   localparam logic [US_W-1:0] RE  = US_W'(T_RST_END - 1);
   localparam logic [US_W-1:0] W0L = US_W'(T_W0_LOW);
   localparam logic [US_W-1:0] W0E = US_W'(T_W0_END - 1);
   localparam logic [US_W-1:0] W1L = US_W'(T_W1_LOW);
   localparam logic [US_W-1:0] BS  = US_W'(T_BIT_SMP - 1);
   localparam logic [US_W-1:0] W1E = US_W'(T_W1_END - 1);

   logic [US_W-1:0] us_q;
   logic [US_W-1:0] lim_low, lim_smp, lim_end;

   always_comb begin
      unique case (cur_op)
         OP_RESET: begin lim_low = RL;  lim_smp = RS; lim_end = RE;  end
         OP_WR0:   begin lim_low = W0L; lim_smp = BS; lim_end = W0E; end
         OP_WR1:   begin lim_low = W1L; lim_smp = BS; lim_end = W1E; end
         default:  begin lim_low = '0;  lim_smp = '0; lim_end = '0;  end
      endcase
   end

   assign pull_low = (cur_op != OP_IDLE) && (us_q < lim_low);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_op <= OP_IDLE;
         us_q   <= '0;
         bit_q  <= 1'b0;
         pres_q <= 1'b0;
      end else if (start) begin
         cur_op <= start_op;
         us_q   <= '0;
      end else if (cur_op != OP_IDLE && tick) begin
         us_q <= us_q + 1'b1;
         if (us_q == lim_smp) begin
            if (cur_op == OP_RESET) pres_q <= ~line_s;
            else                    bit_q  <= line_s;
         end
         if (us_q == lim_end) cur_op <= OP_IDLE;
      end
   end
endmodule

// File: rtl/owire_master.sv
module owire_master
   import owire_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          DIV_W       = 8,
   parameter logic [7:0]  DIV_RESET   = 8'd99,
   parameter int          SYNC_STAGES = 2,
   parameter int          CTRL_OFS    = 0,
   parameter int          DIV_OFS     = 2,
   parameter int          T_RST_LOW   = 480,
   parameter int          T_RST_SMP   = 550,
   parameter int          T_RST_END   = 960,
   parameter int          T_W0_LOW    = 60,
   parameter int          T_W0_END    = 70,
   parameter int          T_W1_LOW    = 6,
   parameter int          T_BIT_SMP   = 15,
   parameter int          T_W1_END    = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              line_in,
   output logic              line_pull_low
);
   localparam int US_W = $clog2(T_RST_END + 1);

   generate
      if (SYNC_STAGES < 2)
         $error("owire_master: SYNC_STAGES must be at least 2");
      if (DIV_W < 1 || DIV_W > 8)
         $error("owire_master: DIV_W must lie in 1..8");
      if (!(T_RST_LOW < T_RST_SMP && T_RST_SMP < T_RST_END))
         $error("owire_master: reset phase order broken");
      if (!(T_W1_LOW < T_BIT_SMP && T_BIT_SMP < T_W1_END && T_BIT_SMP < T_W0_END))
         $error("owire_master: bit slot phase order broken");
      if (!(T_W0_LOW < T_W0_END))
         $error("owire_master: write-0 recovery missing");
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             tick, line_s, busy, start;
   logic             bit_bit, pres_bit;
   op_e              cur_op, req_op;

   logic ctrl_sel, div_sel;
   assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_OFS));
   assign div_sel  = (reg_addr == ADDR_W'(DIV_OFS));

   assign busy   = (cur_op != OP_IDLE);
   assign req_op = pick_op(reg_wdata);
   assign start  = reg_wr && ctrl_sel && !busy && (req_op != OP_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         div_q <= DIV_RESET[DIV_W-1:0];
      else if (reg_wr && div_sel && !busy) div_q <= reg_wdata[DIV_W-1:0];
   end

   owire_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(start), .div(div_q), .tick(tick)
   );

   owire_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
   );

   owire_slot_engine #(
      .T_RST_LOW(T_RST_LOW), .T_RST_SMP(T_RST_SMP), .T_RST_END(T_RST_END),
      .T_W0_LOW(T_W0_LOW),   .T_W0_END(T_W0_END),
      .T_W1_LOW(T_W1_LOW),   .T_BIT_SMP(T_BIT_SMP), .T_W1_END(T_W1_END),
      .US_W(US_W)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .start_op(req_op),
      .line_s(line_s), .cur_op(cur_op), .pull_low(line_pull_low),
      .bit_q(bit_bit), .pres_q(pres_bit)
   );

   always_comb begin
      reg_rdata = '0;
      if (ctrl_sel) begin
         reg_rdata[CB_RST]  = (cur_op == OP_RESET);
         reg_rdata[CB_PRES] = pres_bit;
         reg_rdata[CB_WR0]  = (cur_op == OP_WR0);
         reg_rdata[CB_WR1]  = (cur_op == OP_WR1);
         reg_rdata[CB_BIT]  = bit_bit;
      end else if (div_sel) begin
         reg_rdata[DIV_W-1:0] = div_q;
      end
   end
endmodule

// File: rtl/owire_master_chk.sv
module owire_master_chk
   import owire_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DIV_W    = 8,
   parameter int CTRL_OFS = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              line_pull_low,
   input op_e               cur_op,
   input logic [DIV_W-1:0]  div_q,
   input logic              pres_bit
);
   logic busy;
   assign busy = (cur_op != OP_IDLE);

   // An operation only begins after a control write (R8: no self-start, no restart)
   assert_start_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == ADDR_W'(CTRL_OFS)));

   // Line released whenever idle
   assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_pull_low);

   // Pull-low can only begin together with a new operation
   assert_low_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> $rose(busy));

   // Divider frozen during an operation
   assert_div_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (div_q == $past(div_q)));

   // Presence flag only moves during a reset sequence
   assert_pres_only_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pres_bit != $past(pres_bit)) |-> ($past(cur_op) == OP_RESET));
endmodule

bind owire_master owire_master_chk #(
   .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .line_pull_low(line_pull_low), .cur_op(cur_op), .div_q(div_q),
   .pres_bit(pres_bit)
);

// File: tb/owire_master_bench.sv
module owire_master_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = 4'h0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       line_pull_low;
   logic       slave_low = 1'b0;
   logic       line_in;

   assign line_in = ~(line_pull_low | slave_low);

   always #2 clk = ~clk;   // 250 MHz

   owire_master u_owire_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .line_in(line_in), .line_pull_low(line_pull_low)
   );

   int  n_chk = 0, n_bad = 0;
   int  k = 0;
   bit  finished = 0;
   logic exp_bit = 1'b0, exp_pres = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk); k++;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   function automatic int kind_of(input logic [7:0] c);  // 1 reset, 2 wr0, 3 wr1
      if (c[7]) return 1;
      if (c[5]) return 2;
      if (c[4]) return 3;
      return 0;
   endfunction
   function automatic int low_of(input int kd);
      return (kd == 1) ? 480 : (kd == 2) ? 60 : 6;
   endfunction
   function automatic int end_of(input int kd);
      return (kd == 1) ? 960 : 70;
   endfunction
   function automatic logic [7:0] busy_of(input int kd);
      return (kd == 1) ? 8'h80 : (kd == 2) ? 8'h20 : 8'h10;
   endfunction
   function automatic string req_of(input int kd);
      return (kd == 1) ? "R3" : (kd == 2) ? "R5" : "R6";
   endfunction

   task automatic run_op(input logic [7:0] cmd, input logic slv, input logic [7:0] dv,
                         input bit collide, input bit meddle);
      logic [7:0] r;
      int kd, p, lo, en;
      wr(4'h2, dv);
      rd(4'h2, r); chk("R2 divider readback", r, dv);
      slave_low = slv;
      kd = kind_of(cmd); p = dv + 1; lo = low_of(kd); en = end_of(kd);
      wr(4'h0, cmd); k = 0;
      rd(4'h0, r);
      chk({req_of(kd), "/R9 busy pattern"}, r & 8'hB0, busy_of(kd));
      if (meddle) begin
         wr(4'h0, 8'hB0);
         wr(4'h2, dv ^ 8'h05);
         rd(4'h0, r); chk("R8 command while busy", r & 8'hB0, busy_of(kd));
      end
      while (k < lo * p - 1) step();
      chk({req_of(kd), " low phase end"}, line_pull_low, 1'b1);
      step();
      chk({req_of(kd), " released"}, line_pull_low, 1'b0);
      while (k < en * p - 1) step();
      rd(4'h0, r); chk({req_of(kd), " busy last cycle"}, r & 8'hB0, busy_of(kd));
      if (collide) wr(4'h0, cmd); else step();
      rd(4'h0, r);
      chk(collide ? "R8 write at finish edge" : {req_of(kd), " self-clear"}, r & 8'hB0, 8'h00);
      chk("R10 idle release", line_pull_low, 1'b0);
      if (kd == 1) exp_pres = slv;
      else if (kd == 2) exp_bit = 1'b0;
      else exp_bit = ~slv;
      chk(kd == 1 ? "R4 presence" : "R7 sampled bit", r, {1'b0, exp_pres, 2'b00, exp_bit, 3'b000});
      if (meddle) begin
         rd(4'h2, r); chk("R11 divider held", r, dv);
      end
      slave_low = 1'b0;
      step(); step();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      step();
      rd(4'h0, r); chk("R10 reset control", r, 8'h00);
      rd(4'h2, r); chk("R10 reset divider", r, 8'd99);
      chk("R10 reset line", line_pull_low, 1'b0);

      // R1: inert registers
      for (int a = 4; a <= 12; a += 2) begin
         wr(4'(a), 8'hFF);
         rd(4'(a), r); chk("R1 inert reads zero", r, 8'h00);
      end
      rd(4'h0, r); chk("R1 control untouched", r, 8'h00);
      chk("R1 line untouched", line_pull_low, 1'b0);
      // R9: no command bits -> nothing
      wr(4'h0, 8'h4F);
      step();
      rd(4'h0, r); chk("R9 no command bits", r, 8'h00);
      chk("R9 no command line", line_pull_low, 1'b0);

      // Directed
      run_op(8'h80, 1'b1, 8'd1, 0, 0);   // presence answered
      run_op(8'h80, 1'b0, 8'd0, 0, 0);   // no presence
      run_op(8'h10, 1'b0, 8'd1, 0, 0);   // read 1
      run_op(8'h10, 1'b1, 8'd2, 0, 0);   // read 0
      run_op(8'h20, 1'b0, 8'd1, 0, 0);   // write-0
      run_op(8'h10, 1'b0, 8'd0, 0, 0);
      run_op(8'h80, 1'b1, 8'd0, 0, 0);   // reset must leave bit 3 alone (R7)
      run_op(8'hB0, 1'b0, 8'd0, 0, 0);   // R9 priority -> reset
      run_op(8'h30, 1'b0, 8'd1, 0, 0);   // R9 priority -> write-0
      run_op(8'h10, 1'b0, 8'd1, 1, 0);   // R8 collision at finish
      run_op(8'h10, 1'b1, 8'd1, 0, 1);   // R8/R11 meddling
      run_op(8'h80, 1'b1, 8'd2, 1, 1);

      // Random
      for (int i = 0; i < 16; i++) begin
         logic [7:0] c;
         c = 8'($urandom());
         if ((c & 8'hB0) == 8'h00) c[4] = 1'b1;
         if (c[7] && ($urandom() % 3 != 0)) c[7] = 1'b0;
         if ((c & 8'hB0) == 8'h00) c[5] = 1'b1;
         run_op(c, 1'($urandom()), 8'($urandom() % 4), bit'($urandom() % 2), bit'($urandom() % 2));
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule